// File: doc/BRIEF.md
# Dual-Channel DMA Control and Status Register Bank

This block is the software-visible register bank of a two-channel DMA engine. Each channel has a transfer count, a source and a destination address, a pointer to the next descriptor, a control word, a priority value, a read-only pointer to the descriptor in flight, a completion-interrupt mask and a completion-interrupt status. A plain 32-bit port reaches all of them: byte address, write enable, write data, and read data that follows the address within the same cycle. The register kinds sit in 16-byte groups. Inside each group, channel n's copy sits 4×n bytes above the group base.

On the engine side the bank sends each channel's control word, its decoded address-hold flags, its count and address registers, and two one-cycle commands. The first asks for a descriptor load. The second reports an abort. From the transfer sequencer it takes a load strobe that overwrites the live count, addresses and descriptor pointers, a fetch acknowledge, a busy level and a completion event. A single interrupt line combines the masked completion flags of both channels.

Top module: `dual_dma_csr`

## Requirements
- R1: Channel n (0 or 1) reaches each register at its group base plus 4×n. The group bases are: count 0x00, source 0x10, destination 0x20, next descriptor 0x30, control 0x40, priority 0x60, current descriptor 0x70, mask 0x80, status 0xA0. Count, source, destination and next descriptor keep all 32 written bits. Priority keeps its low PRIO_W bits (default 4) and reads zero above them. A write to one channel leaves the other channel unchanged.
- R2: Any other address reads as zero and changes no state when written. This covers groups 0x50, 0x90 and 0xB0 and up, channel slots 2 and 3 (+0x8, +0xC), and any address whose bits [1:0] are not zero.
- R3: The control word stores these fields: bits [24:22], 21, 17, 16, 12 (enable), 10, 9, [8:6], [5:4] and [3:2], which gives write mask 0x01E317FC. Every other bit reads 0, except bit 14, which reads the channel's sequencer busy input, and bit 13, the pending-fetch flag.
- R4: A control write with bit 13 = 1, while that channel's next-descriptor register is non-zero, sets the pending-fetch flag. On the following cycle fetchStart[n] is high for exactly one cycle. If the next-descriptor register is zero, the write sets no flag and gives no pulse.
- R5: The pending-fetch flag clears on the cycle after seqFetchAck[n]. Writing 0 to bit 13 does not clear it.
- R6: A control write with bit 20 (abort) = 1 and bit 12 (enable) = 0 clears enable and the pending-fetch flag, and gives a one-cycle abortStart[n]. If the same write has enable = 1, it is stored as an ordinary control write and no abort pulse follows. Bit 20 always reads 0.
- R7: Status bit 0 is set on the cycle after seqDone[n]. Writing 0 to that bit clears it. Writing 1 does not change it. When a completion arrives in the same cycle as a clearing write, the flag is set.
- R8: Only mask bit 0 is stored; the other bits read 0. irq is high while any channel has both its status bit 0 and its mask bit 0 set.
- R9: seqLoad[n] loads count, source, destination, next and current descriptor from the sequencer and overrides a bus write made in the same cycle. The current-descriptor register ignores bus writes.
- R10: After reset every register reads zero, and irq, fetchStart and abortStart are low.
- R11: srcHold[n] is control bit 3 and dstHold[n] is control bit 5. Direction code 2 holds the address; code 0 increments it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, same cycle |
| ctrlWord | output | 64 | Control word per channel, channel n at [32n+31:32n] |
| srcHold | output | 2 | Source address held, per channel |
| dstHold | output | 2 | Destination address held, per channel |
| fetchStart | output | 2 | One-cycle descriptor load request |
| abortStart | output | 2 | One-cycle abort command |
| descCount | output | 64 | Count register per channel |
| descSrc | output | 64 | Source address per channel |
| descDst | output | 64 | Destination address per channel |
| descNext | output | 64 | Next descriptor pointer per channel |
| seqLoad | input | 2 | Load live values from the sequencer |
| seqCount | input | 64 | Live count per channel |
| seqSrc | input | 64 | Live source address per channel |
| seqDst | input | 64 | Live destination address per channel |
| seqNext | input | 64 | Next pointer from the loaded descriptor |
| seqCur | input | 64 | Address of the descriptor in flight |
| seqFetchAck | input | 2 | Sequencer accepted the fetch request |
| seqBusy | input | 2 | Sequencer busy per channel |
| seqDone | input | 2 | Completion event per channel |
| irq | output | 1 | Combined completion interrupt |

## Verification
The bench goes after the address-decode edges: slots +0x8 and +0xC, misaligned offsets and empty groups. A decoder that ignored the channel bits or the low address bits would alias those addresses onto real registers and corrupt them. It checks that a fetch request made while the next-descriptor pointer is zero gives no pulse, because a design that skipped that test would start a load from address zero. It checks that abort with enable high is ignored and abort with enable low cancels a pending fetch; if the two were mixed up, a running channel would stop or a stopped channel would keep fetching. It checks the write-0-to-clear status rule, including a completion that arrives in the same cycle as the clear, where the wrong priority loses an interrupt.

// File: rtl/dual_dma_csr_pkg.sv
package dual_dma_csr_pkg;

  localparam int WORD_W = 32;

  // control word bit positions that carry behaviour
  localparam int BIT_SRC_HOLD = 3;
  localparam int BIT_DST_HOLD = 5;
  localparam int BIT_ENABLE   = 12;
  localparam int BIT_FETCH    = 13;
  localparam int BIT_ACTIVE   = 14;
  localparam int BIT_ABORT    = 20;

  // stored control fields: [24:22],21,17,16,12,10,9,[8:6],[5:4],[3:2]
  localparam logic [WORD_W-1:0] CTRL_STORE_MASK = 32'h01E3_17FC;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_COUNT, SEL_SRC, SEL_DST, SEL_NEXT,
    SEL_CTRL, SEL_PRIO, SEL_CUR, SEL_MASK, SEL_STAT
  } regSel_e;

  // per-channel write strobes from control to datapath
  typedef struct packed {
    logic count;
    logic src;
    logic dst;
    logic next;
    logic ctrl;
    logic prio;
    logic mask;
    logic stat;
  } wrStrb_t;

endpackage

// File: rtl/dual_dma_csr_decode.sv
module dual_dma_csr_decode
  import dual_dma_csr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [NUM_CH-1:0]    statBits,
  input  logic [NUM_CH-1:0]    maskBits,
  output wrStrb_t [NUM_CH-1:0] wrStrb,
  output regSel_e              rdSel,
  output logic [1:0]           rdChan,
  output logic                 irq
);

  localparam int GRP_LSB = 4;

  logic [3:0] grp;
  logic [1:0] slot;
  logic       aligned;
  logic       slotOk;
  regSel_e    sel;

  assign grp     = busAddr[GRP_LSB +: 4];
  assign slot    = busAddr[3:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign slotOk  = (int'(slot) < NUM_CH);

  always_comb begin
    sel = SEL_NONE;
    if (aligned && slotOk && (busAddr >> (GRP_LSB + 4)) == '0) begin
      unique case (grp)
        4'h0:    sel = SEL_COUNT;
        4'h1:    sel = SEL_SRC;
        4'h2:    sel = SEL_DST;
        4'h3:    sel = SEL_NEXT;
        4'h4:    sel = SEL_CTRL;
        4'h6:    sel = SEL_PRIO;
        4'h7:    sel = SEL_CUR;
        4'h8:    sel = SEL_MASK;
        4'hA:    sel = SEL_STAT;
        default: sel = SEL_NONE;
      endcase
    end
  end

  assign rdSel  = sel;
  assign rdChan = slot;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_strb
    logic mine;
    assign mine = busWrEn && (int'(slot) == n);
    always_comb begin
      wrStrb[n]       = '0;
      wrStrb[n].count = mine && (sel == SEL_COUNT);
      wrStrb[n].src   = mine && (sel == SEL_SRC);
      wrStrb[n].dst   = mine && (sel == SEL_DST);
      wrStrb[n].next  = mine && (sel == SEL_NEXT);
      wrStrb[n].ctrl  = mine && (sel == SEL_CTRL);
      wrStrb[n].prio  = mine && (sel == SEL_PRIO);
      wrStrb[n].mask  = mine && (sel == SEL_MASK);
      wrStrb[n].stat  = mine && (sel == SEL_STAT);
    end
  end

  assign irq = |(statBits & maskBits);

  // one write target at most per access (R1)
  assert_one_target_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrStrb));

  // unaligned accesses never reach a register (R2)
  assert_unaligned_dead_R2: assert property (@(posedge clk) disable iff (!rstN)
    !aligned |-> (wrStrb == '0));

endmodule

// File: rtl/dual_dma_csr_regs.sv
module dual_dma_csr_regs
  import dual_dma_csr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int PRIO_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  wrStrb_t [NUM_CH-1:0]     wrStrb,
  input  regSel_e                  rdSel,
  input  logic [1:0]               rdChan,
  input  logic [WORD_W-1:0]        busWrData,
  output logic [WORD_W-1:0]        busRdData,
  output logic [NUM_CH*WORD_W-1:0] ctrlWord,
  output logic [NUM_CH-1:0]        srcHold,
  output logic [NUM_CH-1:0]        dstHold,
  output logic [NUM_CH-1:0]        fetchStart,
  output logic [NUM_CH-1:0]        abortStart,
  output logic [NUM_CH*WORD_W-1:0] descCount,
  output logic [NUM_CH*WORD_W-1:0] descSrc,
  output logic [NUM_CH*WORD_W-1:0] descDst,
  output logic [NUM_CH*WORD_W-1:0] descNext,
  input  logic [NUM_CH-1:0]        seqLoad,
  input  logic [NUM_CH*WORD_W-1:0] seqCount,
  input  logic [NUM_CH*WORD_W-1:0] seqSrc,
  input  logic [NUM_CH*WORD_W-1:0] seqDst,
  input  logic [NUM_CH*WORD_W-1:0] seqNext,
  input  logic [NUM_CH*WORD_W-1:0] seqCur,
  input  logic [NUM_CH-1:0]        seqFetchAck,
  input  logic [NUM_CH-1:0]        seqBusy,
  input  logic [NUM_CH-1:0]        seqDone,
  output logic [NUM_CH-1:0]        statBits,
  output logic [NUM_CH-1:0]        maskBits
);

  logic [WORD_W-1:0] rdVec [NUM_CH];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [WORD_W-1:0] cntQ, srcQ, dstQ, nxtQ, curQ, ctrlQ, ctrlView;
    logic [PRIO_W-1:0] prioQ;
    logic              maskQ, statQ, fetchQ, fetchPulseQ, abortPulseQ;
    logic              abortCmd, fetchSet;

    assign abortCmd = wrStrb[n].ctrl && busWrData[BIT_ABORT] && !busWrData[BIT_ENABLE];
    assign fetchSet = wrStrb[n].ctrl && busWrData[BIT_FETCH] && !abortCmd && (nxtQ != '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ        <= '0;
        srcQ        <= '0;
        dstQ        <= '0;
        nxtQ        <= '0;
        curQ        <= '0;
        ctrlQ       <= '0;
        prioQ       <= '0;
        maskQ       <= 1'b0;
        statQ       <= 1'b0;
        fetchQ      <= 1'b0;
        fetchPulseQ <= 1'b0;
        abortPulseQ <= 1'b0;
      end else begin
        if (seqLoad[n]) begin
          cntQ <= seqCount[n*WORD_W +: WORD_W];
          srcQ <= seqSrc[n*WORD_W +: WORD_W];
          dstQ <= seqDst[n*WORD_W +: WORD_W];
          nxtQ <= seqNext[n*WORD_W +: WORD_W];
          curQ <= seqCur[n*WORD_W +: WORD_W];
        end else begin
          if (wrStrb[n].count) cntQ <= busWrData;
          if (wrStrb[n].src)   srcQ <= busWrData;
          if (wrStrb[n].dst)   dstQ <= busWrData;
          if (wrStrb[n].next)  nxtQ <= busWrData;
        end
        if (wrStrb[n].ctrl) ctrlQ <= busWrData & CTRL_STORE_MASK;
        if (wrStrb[n].prio) prioQ <= busWrData[PRIO_W-1:0];
        if (wrStrb[n].mask) maskQ <= busWrData[0];
        if (seqDone[n])
          statQ <= 1'b1;
        else if (wrStrb[n].stat && !busWrData[0])
          statQ <= 1'b0;
        if (fetchSet)
          fetchQ <= 1'b1;
        else if (abortCmd || seqFetchAck[n])
          fetchQ <= 1'b0;
        fetchPulseQ <= fetchSet && (!fetchQ || seqFetchAck[n]);
        abortPulseQ <= abortCmd;
      end
    end

    always_comb begin
      ctrlView             = ctrlQ;
      ctrlView[BIT_FETCH]  = fetchQ;
      ctrlView[BIT_ACTIVE] = seqBusy[n];
    end

    always_comb begin
      unique case (rdSel)
        SEL_COUNT: rdVec[n] = cntQ;
        SEL_SRC:   rdVec[n] = srcQ;
        SEL_DST:   rdVec[n] = dstQ;
        SEL_NEXT:  rdVec[n] = nxtQ;
        SEL_CTRL:  rdVec[n] = ctrlView;
        SEL_PRIO:  rdVec[n] = WORD_W'(prioQ);
        SEL_CUR:   rdVec[n] = curQ;
        SEL_MASK:  rdVec[n] = WORD_W'(maskQ);
        SEL_STAT:  rdVec[n] = WORD_W'(statQ);
        default:   rdVec[n] = '0;
      endcase
    end

    assign ctrlWord[n*WORD_W +: WORD_W]  = ctrlView;
    assign descCount[n*WORD_W +: WORD_W] = cntQ;
    assign descSrc[n*WORD_W +: WORD_W]   = srcQ;
    assign descDst[n*WORD_W +: WORD_W]   = dstQ;
    assign descNext[n*WORD_W +: WORD_W]  = nxtQ;
    assign srcHold[n]    = ctrlQ[BIT_SRC_HOLD];
    assign dstHold[n]    = ctrlQ[BIT_DST_HOLD];
    assign fetchStart[n] = fetchPulseQ;
    assign abortStart[n] = abortPulseQ;
    assign statBits[n]   = statQ;
    assign maskBits[n]   = maskQ;

    // a fetch pulse is only issued with a pending fetch behind it (R4)
    assert_fetch_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
      fetchStart[n] |-> fetchQ);

    // acknowledge retires the request (R5)
    assert_fetch_retire_R5: assert property (@(posedge clk) disable iff (!rstN)
      (seqFetchAck[n] && !fetchSet) |=> !fetchQ);

    // an abort pulse leaves the channel disabled and idle (R6)
    assert_abort_stops_R6: assert property (@(posedge clk) disable iff (!rstN)
      abortStart[n] |-> (!ctrlQ[BIT_ENABLE] && !fetchQ));

    // completion always lands (R7)
    assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
      seqDone[n] |=> statQ);

    // current descriptor only moves on a sequencer load (R9)
    assert_cur_readonly_R9: assert property (@(posedge clk) disable iff (!rstN)
      !seqLoad[n] |=> $stable(curQ));
  end

  always_comb begin
    busRdData = '0;
    for (int n = 0; n < NUM_CH; n++)
      if (int'(rdChan) == n) busRdData = rdVec[n];
  end

endmodule

// File: rtl/dual_dma_csr.sv
module dual_dma_csr
  import dual_dma_csr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int PRIO_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWrEn,
  input  logic [WORD_W-1:0]        busWrData,
  output logic [WORD_W-1:0]        busRdData,
  output logic [NUM_CH*WORD_W-1:0] ctrlWord,
  output logic [NUM_CH-1:0]        srcHold,
  output logic [NUM_CH-1:0]        dstHold,
  output logic [NUM_CH-1:0]        fetchStart,
  output logic [NUM_CH-1:0]        abortStart,
  output logic [NUM_CH*WORD_W-1:0] descCount,
  output logic [NUM_CH*WORD_W-1:0] descSrc,
  output logic [NUM_CH*WORD_W-1:0] descDst,
  output logic [NUM_CH*WORD_W-1:0] descNext,
  input  logic [NUM_CH-1:0]        seqLoad,
  input  logic [NUM_CH*WORD_W-1:0] seqCount,
  input  logic [NUM_CH*WORD_W-1:0] seqSrc,
  input  logic [NUM_CH*WORD_W-1:0] seqDst,
  input  logic [NUM_CH*WORD_W-1:0] seqNext,
  input  logic [NUM_CH*WORD_W-1:0] seqCur,
  input  logic [NUM_CH-1:0]        seqFetchAck,
  input  logic [NUM_CH-1:0]        seqBusy,
  input  logic [NUM_CH-1:0]        seqDone,
  output logic                     irq
);

  wrStrb_t [NUM_CH-1:0] wrStrb;
  regSel_e              rdSel;
  logic [1:0]           rdChan;
  logic [NUM_CH-1:0]    statBits;
  logic [NUM_CH-1:0]    maskBits;

  dual_dma_csr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .statBits (statBits),
    .maskBits (maskBits),
    .wrStrb   (wrStrb),
    .rdSel    (rdSel),
    .rdChan   (rdChan),
    .irq      (irq)
  );

  dual_dma_csr_regs #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .wrStrb      (wrStrb),
    .rdSel       (rdSel),
    .rdChan      (rdChan),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .ctrlWord    (ctrlWord),
    .srcHold     (srcHold),
    .dstHold     (dstHold),
    .fetchStart  (fetchStart),
    .abortStart  (abortStart),
    .descCount   (descCount),
    .descSrc     (descSrc),
    .descDst     (descDst),
    .descNext    (descNext),
    .seqLoad     (seqLoad),
    .seqCount    (seqCount),
    .seqSrc      (seqSrc),
    .seqDst      (seqDst),
    .seqNext     (seqNext),
    .seqCur      (seqCur),
    .seqFetchAck (seqFetchAck),
    .seqBusy     (seqBusy),
    .seqDone     (seqDone),
    .statBits    (statBits),
    .maskBits    (maskBits)
  );

  // interrupt is silent whenever every mask bit is clear (R8)
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (maskBits == '0) |-> !irq);

endmodule

// File: tb/dual_dma_csr_test.sv
`timescale 1ns/1ps
module dual_dma_csr_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [63:0] ctrlWord, descCount, descSrc, descDst, descNext;
  logic [1:0]  srcHold, dstHold, fetchStart, abortStart;
  logic [1:0]  seqLoad = '0, seqFetchAck = '0, seqBusy = '0, seqDone = '0;
  logic [63:0] seqCount = '0, seqSrc = '0, seqDst = '0, seqNext = '0, seqCur = '0;
  logic        irq;

  int total = 0;
  int bad = 0;

  // model of the plain registers: index [ch][group 0..3 count/src/dst/next, 4 prio]
  logic [31:0] model [2][5];

  always #2.5 clk = ~clk;

  dual_dma_csr uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .ctrlWord(ctrlWord),
    .srcHold(srcHold), .dstHold(dstHold), .fetchStart(fetchStart),
    .abortStart(abortStart), .descCount(descCount), .descSrc(descSrc),
    .descDst(descDst), .descNext(descNext), .seqLoad(seqLoad),
    .seqCount(seqCount), .seqSrc(seqSrc), .seqDst(seqDst), .seqNext(seqNext),
    .seqCur(seqCur), .seqFetchAck(seqFetchAck), .seqBusy(seqBusy),
    .seqDone(seqDone), .irq(irq)
  );

  function automatic logic [7:0] addrOf(int grpBase, int ch);
    return 8'(grpBase + 4 * ch);
  endfunction

  function automatic int baseOfIdx(int idx);
    case (idx)
      0: return 'h00;
      1: return 'h10;
      2: return 'h20;
      3: return 'h30;
      default: return 'h60;
    endcase
  endfunction

  function automatic logic [31:0] keepOfIdx(int idx, logic [31:0] d);
    return (idx == 4) ? (d & 32'hF) : d;
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #0.5;
    d = busRdData;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  logic [31:0] rd;

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < 2; c++) for (int i = 0; i < 5; i++) model[c][i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();

    // R10 reset state
    for (int c = 0; c < 2; c++) begin
      foreach (model[0][i]) begin
        busRead(addrOf(baseOfIdx(i), c), rd); check("R10 reset reg", rd, 32'h0);
      end
      busRead(addrOf('h40, c), rd); check("R10 reset ctrl", rd, 32'h0);
      busRead(addrOf('hA0, c), rd); check("R10 reset stat", rd, 32'h0);
    end
    check("R10 reset irq/pulses", {irq, fetchStart, abortStart}, 32'h0);

    // R3 control fields, reserved bits, active bit; R11 hold flags
    busWrite(addrOf('h40, 0), 32'hFFFF_FFFF);
    busRead(addrOf('h40, 0), rd); check("R3 ctrl store mask", rd, 32'h01E3_17FC);
    busRead(addrOf('h40, 1), rd); check("R1 ctrl other channel untouched", rd, 32'h0);
    check("R11 both holds set", {srcHold[0], dstHold[0]}, 32'h3);
    seqBusy = 2'b01; #0.5;
    busRead(addrOf('h40, 0), rd); check("R3 active bit follows busy", rd, 32'h01E3_57FC);
    seqBusy = 2'b00;
    busWrite(addrOf('h40, 1), 32'h0000_0020);
    check("R11 dst held src increments", {srcHold[1], dstHold[1]}, 32'h1);
    busWrite(addrOf('h40, 1), 32'h0000_0008);
    check("R11 src held dst increments", {srcHold[1], dstHold[1]}, 32'h2);
    busWrite(addrOf('h40, 0), 32'h0);

    // R4 fetch with empty pointer: nothing
    busWrite(addrOf('h40, 0), 32'h0000_2000);
    check("R4 no pulse with zero pointer", fetchStart, 32'h0);
    busRead(addrOf('h40, 0), rd); check("R4 no pending with zero pointer", rd, 32'h0);
    // R4 fetch with valid pointer
    busWrite(addrOf('h30, 0), 32'h0000_0100); model[0][3] = 32'h100;
    busWrite(addrOf('h40, 0), 32'h0000_3000);
    check("R4 fetch pulse", fetchStart, 32'h1);
    busRead(addrOf('h40, 0), rd); check("R4 pending flag", rd, 32'h0000_3000);
    tick();
    check("R4 pulse one cycle", fetchStart, 32'h0);
    // R5 write 0 does not cancel, ack does
    busWrite(addrOf('h40, 0), 32'h0000_1000);
    busRead(addrOf('h40, 0), rd); check("R5 write 0 keeps pending", rd, 32'h0000_3000);
    seqFetchAck = 2'b01; tick(); seqFetchAck = 2'b00;
    busRead(addrOf('h40, 0), rd); check("R5 ack clears pending", rd, 32'h0000_1000);

    // R6 abort with enable low stops and cancels fetch
    busWrite(addrOf('h40, 0), 32'h0000_3000);
    tick();
    busWrite(addrOf('h40, 0), 32'h0010_0000);
    check("R6 abort pulse", abortStart, 32'h1);
    busRead(addrOf('h40, 0), rd); check("R6 abort stops channel", rd, 32'h0);
    tick();
    check("R6 abort pulse one cycle", abortStart, 32'h0);
    busWrite(addrOf('h40, 0), 32'h0010_1000);
    check("R6 abort with enable ignored", abortStart, 32'h0);
    busRead(addrOf('h40, 0), rd); check("R6 abort bit reads zero", rd, 32'h0000_1000);
    busWrite(addrOf('h40, 0), 32'h0);

    // R1 random register traffic, checked against the model
    for (int it = 0; it < 60; it++) begin
      int c = $urandom_range(1, 0);
      int i = $urandom_range(4, 0);
      logic [31:0] d = $urandom();
      if (i == 3 && d == 0) d = 32'h4;
      busWrite(addrOf(baseOfIdx(i), c), d);
      model[c][i] = keepOfIdx(i, d);
      for (int cc = 0; cc < 2; cc++) begin
        int j = $urandom_range(4, 0);
        busRead(addrOf(baseOfIdx(j), cc), rd);
        check("R1 register readback", rd, model[cc][j]);
      end
    end

    // R2 unmapped addresses
    begin
      logic [7:0] holes [6] = '{8'h50, 8'h48, 8'h9C, 8'hC0, 8'h41, 8'h3C};
      foreach (holes[k]) begin
        busWrite(holes[k], 32'hFFFF_FFFF);
        busRead(holes[k], rd); check("R2 unmapped reads zero", rd, 32'h0);
      end
    end
    for (int c = 0; c < 2; c++) begin
      foreach (model[0][i]) begin
        busRead(addrOf(baseOfIdx(i), c), rd); check("R2 mapped regs unchanged", rd, model[c][i]);
      end
      busRead(addrOf('h40, c), rd); check("R2 ctrl unchanged", rd, (c == 0) ? 32'h0 : 32'h8);
    end

    // R8 mask storage, R7 status behaviour
    busWrite(addrOf('h80, 0), 32'hFFFF_FFFF);
    busRead(addrOf('h80, 0), rd); check("R8 mask bit 0 only", rd, 32'h1);
    check("R8 irq low without status", irq, 32'h0);
    seqDone = 2'b01; tick(); seqDone = 2'b00;
    busRead(addrOf('hA0, 0), rd); check("R7 completion sets status", rd, 32'h1);
    check("R8 irq with mask and status", irq, 32'h1);
    busWrite(addrOf('hA0, 0), 32'h1);
    busRead(addrOf('hA0, 0), rd); check("R7 write 1 keeps status", rd, 32'h1);
    busWrite(addrOf('hA0, 0), 32'h0);
    busRead(addrOf('hA0, 0), rd); check("R7 write 0 clears status", rd, 32'h0);
    check("R8 irq drops", irq, 32'h0);
    seqDone = 2'b10; tick(); seqDone = 2'b00;
    check("R8 unmasked channel 1 no irq", irq, 32'h0);
    busWrite(addrOf('h80, 1), 32'h1);
    check("R8 channel 1 irq", irq, 32'h1);
    @(negedge clk);
    busAddr = addrOf('hA0, 1); busWrData = 32'h0; busWrEn = 1'b1; seqDone = 2'b10;
    @(negedge clk);
    busWrEn = 1'b0; seqDone = 2'b00;
    busRead(addrOf('hA0, 1), rd); check("R7 set wins over clear", rd, 32'h1);

    // R9 sequencer load overrides bus, current descriptor read-only
    busWrite(addrOf('h70, 1), 32'hDEAD_BEEF);
    busRead(addrOf('h70, 1), rd); check("R9 cur ignores bus write", rd, 32'h0);
    @(negedge clk);
    seqCount[63:32] = 32'h0000_0040; seqSrc[63:32] = 32'h1000_0000;
    seqDst[63:32] = 32'h2000_0000; seqNext[63:32] = 32'h0000_0200;
    seqCur[63:32] = 32'h0000_0180; seqLoad = 2'b10;
    busAddr = addrOf('h00, 1); busWrData = 32'h1234_5678; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; seqLoad = 2'b00;
    busRead(addrOf('h00, 1), rd); check("R9 load beats bus write", rd, 32'h0000_0040);
    busRead(addrOf('h10, 1), rd); check("R9 load source", rd, 32'h1000_0000);
    busRead(addrOf('h20, 1), rd); check("R9 load destination", rd, 32'h2000_0000);
    busRead(addrOf('h30, 1), rd); check("R9 load next", rd, 32'h0000_0200);
    busRead(addrOf('h70, 1), rd); check("R9 load current", rd, 32'h0000_0180);
    check("R9 count port", descCount[63:32], 32'h0000_0040);
    busRead(addrOf('h00, 0), rd); check("R9 other channel kept", rd, model[0][0]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule